// File: doc/BRIEF.md
# Vector Mask Compress and Expand Unit

This unit moves elements of a short vector between positions under a per-element selection mask. In pack mode it collects the source elements whose mask bit is set and writes them, in their original relative order, into the lowest destination slots, reporting how many it placed. In scatter mode it performs the inverse. It takes consecutive source elements from element 0 upward and drops each one into the next slot whose mask bit is set. Any slot not written by the operation keeps the value supplied on a background vector.

A request is accepted on a single-cycle start strobe while the unit is idle. Operands are captured at that edge, and the unit then scans one mask position per clock. After the last position has been scanned, the unit raises a one-cycle valid flag. The result vector and the element count are registered and stay stable until the next accepted request.

Top module: `vcx_unit`

## Requirements
- R1: After synchronous reset, `valid` is 0, `pack_cnt` is 0 and every element of `result_vec` is 0.
- R2: With `op_sel` = 0 (pack), the source elements at positions whose mask bit is 1 appear in destination positions 0, 1, 2, ... in ascending order of their source position. For mask 8'b1011_0010 the destination slots 0..3 hold source elements 1, 4, 5 and 7.
- R3: When `valid` is 1, `pack_cnt` equals the number of 1 bits in the mask accepted with the request, for both modes.
- R4: In pack mode, every destination position at or above `pack_cnt` holds the corresponding element of the background vector.
- R5: With `op_sel` = 1 (scatter), the k-th lowest set mask position receives source element k, counting k from 0.
- R6: In scatter mode, every destination position whose mask bit is 0 holds the corresponding background element.
- R7: `valid` is 1 for exactly one cycle, following the 8th rising edge after the edge that accepts `start`. It is 0 in all other cycles.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. The running operation completes with its own operands and timing.
- R9: An all-zero mask gives `pack_cnt` = 0 and a result equal to the background vector in both modes.
- R10: Element k of a flat vector port occupies bits [k*DW +: DW], with element 0 in the least significant bits, and mask bit k belongs to element k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, accepted only when idle |
| op_sel | input | 1 | 0 = pack (compress), 1 = scatter (expand) |
| mask | input | ELEMS | Per-element selection mask |
| src_vec | input | ELEMS*DW | Source vector, element 0 in the low bits |
| bg_vec | input | ELEMS*DW | Background vector for slots that are not written |
| result_vec | output | ELEMS*DW | Registered result vector |
| pack_cnt | output | $clog2(ELEMS+1) | Number of selected elements |
| valid | output | 1 | One-cycle completion flag |

## Verification
A write pointer that steps wrongly or misses a step shows up as elements that are shifted or duplicated in the result, or as a wrong count, once the scan ends. This is visible at `valid`, nine edges after the start strobe. The test sweeps every mask value in both modes. The source and background elements each carry a unique tag, so any element that lands in the wrong slot can be identified. An error in the position counter shows instead as `valid` arriving in the wrong cycle or lasting more than one cycle, which is visible within the same operation.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  typedef enum logic {
    OP_PACK    = 1'b0,
    OP_SCATTER = 1'b1
  } vcx_op_e;
endpackage

// File: rtl/vcx_seq.sv
module vcx_seq #(
  parameter int ELEMS = 8,
  localparam int IW = (ELEMS > 1) ? $clog2(ELEMS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          load,
  output logic          busy,
  output logic          last,
  output logic [IW-1:0] idx,
  output logic          valid
);
  localparam logic [IW-1:0] LAST_IDX = IW'(ELEMS - 1);

  assign load = start && !busy;
  assign last = busy && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      idx   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= last;
      if (load) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        if (last) begin
          busy <= 1'b0;
          idx  <= '0;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/vcx_lanes.sv
module vcx_lanes
  import vcx_pkg::*;
#(
  parameter int ELEMS = 8,
  parameter int DW    = 8,
  localparam int IW = (ELEMS > 1) ? $clog2(ELEMS) : 1,
  localparam int CW = $clog2(ELEMS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              last,
  input  logic [IW-1:0]     idx,
  input  logic              op_in,
  input  logic [ELEMS-1:0]  mask_in,
  input  logic [ELEMS*DW-1:0] src_in,
  input  logic [ELEMS*DW-1:0] bg_in,
  output logic [ELEMS*DW-1:0] result,
  output logic [CW-1:0]     count
);
  logic [DW-1:0]    src_q [ELEMS];
  logic [DW-1:0]    res_q [ELEMS];
  logic [ELEMS-1:0] mask_q;
  vcx_op_e          op_q;
  logic [CW-1:0]    ptr_q;
  logic [IW-1:0]    ptr_i;
  logic             hit;

  assign ptr_i = ptr_q[IW-1:0];
  assign hit   = step && mask_q[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      op_q   <= OP_PACK;
      ptr_q  <= '0;
      count  <= '0;
    end else begin
      if (load) begin
        mask_q <= mask_in;
        op_q   <= vcx_op_e'(op_in);
        ptr_q  <= '0;
      end else if (hit) begin
        ptr_q <= ptr_q + 1'b1;
      end
      if (last) begin
        count <= ptr_q + CW'(hit);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      for (int k = 0; k < ELEMS; k++) begin
        src_q[k] <= src_in[k*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < ELEMS; k++) begin
        res_q[k] <= '0;
      end
    end else if (load) begin
      for (int k = 0; k < ELEMS; k++) begin
        res_q[k] <= bg_in[k*DW +: DW];
      end
    end else if (hit) begin
      if (op_q == OP_PACK) begin
        res_q[ptr_i] <= src_q[idx];
      end else begin
        res_q[idx] <= src_q[ptr_i];
      end
    end
  end

  for (genvar g = 0; g < ELEMS; g++) begin : g_out
    assign result[g*DW +: DW] = res_q[g];
  end
endmodule

// File: rtl/vcx_unit.sv
module vcx_unit #(
  parameter int ELEMS = 8,
  parameter int DW    = 8,
  localparam int IW = (ELEMS > 1) ? $clog2(ELEMS) : 1,
  localparam int CW = $clog2(ELEMS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                op_sel,
  input  logic [ELEMS-1:0]    mask,
  input  logic [ELEMS*DW-1:0] src_vec,
  input  logic [ELEMS*DW-1:0] bg_vec,
  output logic [ELEMS*DW-1:0] result_vec,
  output logic [CW-1:0]       pack_cnt,
  output logic                valid
);
  logic          load;
  logic          busy;
  logic          last;
  logic [IW-1:0] idx;

  vcx_seq #(.ELEMS(ELEMS)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .busy  (busy),
    .last  (last),
    .idx   (idx),
    .valid (valid)
  );

  vcx_lanes #(.ELEMS(ELEMS), .DW(DW)) u_lanes (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .step    (busy),
    .last    (last),
    .idx     (idx),
    .op_in   (op_sel),
    .mask_in (mask),
    .src_in  (src_vec),
    .bg_in   (bg_vec),
    .result  (result_vec),
    .count   (pack_cnt)
  );
endmodule

// File: rtl/vcx_unit_chk.sv
module vcx_unit_chk #(
  parameter int ELEMS = 8,
  parameter int DW    = 8,
  localparam int IW = (ELEMS > 1) ? $clog2(ELEMS) : 1,
  localparam int CW = $clog2(ELEMS + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [ELEMS-1:0]    mask,
  input logic                busy,
  input logic [IW-1:0]       idx,
  input logic                valid,
  input logic [ELEMS*DW-1:0] result_vec,
  input logic [CW-1:0]       pack_cnt
);
  logic [ELEMS-1:0] mask_snap;

  always_ff @(posedge clk) begin
    if (rst) mask_snap <= '0;
    else if (start && !busy) mask_snap <= mask;
  end

  // R7: completion flag lasts a single cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R7: completion only after the scan has just ended
  p_valid_after_scan_r7: assert property (@(posedge clk) disable iff (rst)
    valid |-> (!busy && $past(busy)));

  // R3: count matches the number of selected elements
  p_count_popcount_r3: assert property (@(posedge clk) disable iff (rst)
    valid |-> (pack_cnt == CW'($countones(mask_snap))));

  // R8: a strobe during a scan does not restart the position counter
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && idx != IW'(ELEMS - 1)) |=> (busy && idx == $past(idx) + 1'b1));

  // R2: result holds steady while idle and no request arrives
  p_result_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(result_vec));
endmodule

bind vcx_unit vcx_unit_chk #(.ELEMS(ELEMS), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .mask       (mask),
  .busy       (busy),
  .idx        (idx),
  .valid      (valid),
  .result_vec (result_vec),
  .pack_cnt   (pack_cnt)
);

// File: tb/vcx_unit_test.sv
module vcx_unit_test;
  localparam int ELEMS = 8;
  localparam int DW    = 8;
  localparam int CW    = $clog2(ELEMS + 1);

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                start = 1'b0;
  logic                op_sel = 1'b0;
  logic [ELEMS-1:0]    mask = '0;
  logic [ELEMS*DW-1:0] src_vec = '0;
  logic [ELEMS*DW-1:0] bg_vec = '0;
  logic [ELEMS*DW-1:0] result_vec;
  logic [CW-1:0]       pack_cnt;
  logic                valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vcx_unit #(.ELEMS(ELEMS), .DW(DW)) uut (
    .clk(clk), .rst(rst), .start(start), .op_sel(op_sel), .mask(mask),
    .src_vec(src_vec), .bg_vec(bg_vec), .result_vec(result_vec),
    .pack_cnt(pack_cnt), .valid(valid)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ELEMS*DW-1:0] make_src(input logic [ELEMS-1:0] m);
    logic [ELEMS*DW-1:0] v;
    for (int k = 0; k < ELEMS; k++) v[k*DW +: DW] = {m[3:0] ^ 4'hA, 4'(k)};
    return v;
  endfunction

  function automatic logic [ELEMS*DW-1:0] make_bg(input logic [ELEMS-1:0] m);
    logic [ELEMS*DW-1:0] v;
    for (int k = 0; k < ELEMS; k++) v[k*DW +: DW] = {m[7:4] ^ 4'h5, 4'(k + 8)};
    return v;
  endfunction

  function automatic logic [ELEMS*DW-1:0] model(input logic op, input logic [ELEMS-1:0] m,
      input logic [ELEMS*DW-1:0] s, input logic [ELEMS*DW-1:0] b);
    logic [ELEMS*DW-1:0] r;
    int n;
    r = b;
    n = 0;
    for (int k = 0; k < ELEMS; k++) begin
      if (m[k]) begin
        if (!op) r[n*DW +: DW] = s[k*DW +: DW];
        else     r[k*DW +: DW] = s[n*DW +: DW];
        n++;
      end
    end
    return r;
  endfunction

  task automatic run(input logic op, input logic [ELEMS-1:0] m, input bit poke, input string req);
    logic [ELEMS*DW-1:0] s, b;
    s = make_src(m);
    b = make_bg(m);
    @(negedge clk);
    op_sel = op; mask = m; src_vec = s; bg_vec = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({"R7 valid low at accept ", req}, 128'(valid), 128'(0));
    if (poke) begin
      op_sel = ~op; mask = ~m; src_vec = ~s; bg_vec = ~b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
    end else begin
      repeat (7) @(negedge clk);
    end
    check({"R7 valid low before end ", req}, 128'(valid), 128'(0));
    @(negedge clk);
    check({"R7 valid at end ", req}, 128'(valid), 128'(1));
    check({req, " result"}, 128'(result_vec), 128'(model(op, m, s, b)));
    check({"R3 count ", req}, 128'(pack_cnt), 128'($countones(m)));
    @(negedge clk);
    check({"R7 valid single cycle ", req}, 128'(valid), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid after reset", 128'(valid), 128'(0));
    check("R1 count after reset", 128'(pack_cnt), 128'(0));
    check("R1 result after reset", 128'(result_vec), 128'(0));
    rst = 1'b0;

    // R2 stated example: mask 1011_0010 packs elements 1,4,5,7
    run(1'b0, 8'b1011_0010, 1'b0, "R2 example");
    check("R2 example slot0", 128'(result_vec[7:0]),   128'({4'hA ^ 4'h2, 4'd1}));
    check("R2 example slot3", 128'(result_vec[31:24]), 128'({4'hA ^ 4'h2, 4'd7}));
    check("R4 example slot4 background", 128'(result_vec[39:32]), 128'({4'h5 ^ 4'hB, 4'd12}));

    // R9 all-zero mask
    run(1'b0, 8'h00, 1'b0, "R9 pack zero mask");
    check("R9 pack equals background", 128'(result_vec), 128'(make_bg(8'h00)));
    run(1'b1, 8'h00, 1'b0, "R9 scatter zero mask");
    check("R9 scatter equals background", 128'(result_vec), 128'(make_bg(8'h00)));

    // R8 start during scan ignored
    run(1'b0, 8'b1011_0010, 1'b1, "R8 pack busy strobe");
    run(1'b1, 8'b0110_1001, 1'b1, "R8 scatter busy strobe");

    // R2 R4 R5 R6 R10 sweep over every mask in both modes
    for (int m = 0; m < 256; m++) begin
      run(1'b0, 8'(m), 1'b0, "R2 R4 R10 pack sweep");
      run(1'b1, 8'(m), 1'b0, "R5 R6 R10 scatter sweep");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule